// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Bit Peripheral Takeover

This block is a bidirectional general-purpose I/O port of `WIDTH` bits (8 by default). Software reaches it over a small register bus. The bus has separate write and read strobes for three registers and one shared data bus. The three registers are the output latch, the port (pin) view and the direction register. A direction bit of 1 makes its pin an input. A direction bit of 0 drives the latched value onto the pad. The block produces per-pin output data and output enables for tristate pads. It also returns synchronized pad levels to on-chip peripherals.

Any bit can be taken over by a peripheral through a per-bit select. While the select is active, the peripheral's data-out and output-enable drive that pin. The override acts only on the pad drive. It is never written into the stored direction bits, so a software read-modify-write of the direction register stays correct while peripherals own some pins. Reads of the latch and reads of the pins use separate paths.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones and the output latch reads zero. With no peripheral select active, `pad_oe` is all zero.
- R2: For a bit whose `periph_sel` is 0, `pad_oe` is the inverse of that bit's direction bit and `pad_out` is that bit's latch bit.
- R3: A `wr_lat` or a `wr_port` strobe loads `wdata` into the same output latch at the next rising clock edge.
- R4: While `rd_lat` is asserted (and `rd_dir` is not), `rdata` returns the stored latch value, whatever the pad levels are.
- R5: A `pad_in` level becomes visible on `periph_din` and through `rd_port` after exactly two rising clock edges.
- R6: For a bit whose `periph_sel` is 1, `pad_out` follows `periph_dout` instead of the latch.
- R7: For a bit whose `periph_sel` is 1, `pad_oe` follows `periph_oe`. The override never changes the direction register as read through `rd_dir`.
- R8: A `wr_dir` strobe loads `wdata` into the direction register at the next rising edge, and `rd_dir` returns it. Writing 0xCF makes bits 5:4 outputs (`pad_oe` = 0x30) and all other bits inputs.
- R9: The read strobes are prioritized `rd_dir` over `rd_lat` over `rd_port`. With no read strobe, `rdata` is zero.
- R10: With no write strobe, the latch and direction registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lat | input | 1 | Write strobe, output latch address |
| wr_port | input | 1 | Write strobe, port address (loads the latch) |
| wr_dir | input | 1 | Write strobe, direction register |
| rd_lat | input | 1 | Read strobe, output latch |
| rd_port | input | 1 | Read strobe, synchronized pad levels |
| rd_dir | input | 1 | Read strobe, direction register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data |
| periph_sel | input | WIDTH | Per-bit peripheral takeover select |
| periph_dout | input | WIDTH | Peripheral output data |
| periph_oe | input | WIDTH | Peripheral output enable (1 = drive) |
| pad_in | input | WIDTH | Raw pad input levels |
| pad_out | output | WIDTH | Pad output data |
| pad_oe | output | WIDTH | Pad output enable (1 = drive) |
| periph_din | output | WIDTH | Synchronized pad levels to peripherals |

## Verification
The bench builds the block with its default values, `WIDTH` = 8 and `SYNC_STAGES` = 2. At this width the documented 0xCF direction pattern and a random mix of per-bit takeovers can be checked on every bit. The two-stage synchronizer makes the two-edge input latency a checkable constant. The reference model's delay queue is sized from the same parameter, so the pad-to-read timing is compared on every cycle. Random strobe combinations, including simultaneous reads and writes, exercise the read priority and the shared latch address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Source selected for the read data bus
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PORT = 2'd1,
        RSEL_LAT  = 2'd2,
        RSEL_DIR  = 2'd3
    } rd_src_e;

    // Direction first, then latch, then pins
    function automatic rd_src_e pick_read(input logic rd_dir, input logic rd_lat,
                                          input logic rd_port);
        if (rd_dir)       return RSEL_DIR;
        else if (rd_lat)  return RSEL_LAT;
        else if (rd_port) return RSEL_PORT;
        else              return RSEL_NONE;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[SYNC_STAGES-1];

    // Cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_chk2
            // R5: two-edge latency from pad to synchronized output
            p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> (sync_out == $past(async_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lat,
    input  logic             wr_port,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_bits,
    output logic [WIDTH-1:0] lat_bits
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_lat || wr_port) regs_d.lat = wdata;
        if (wr_dir)            regs_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir <= '1;
            regs_q.lat <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_bits = regs_q.dir;
    assign lat_bits = regs_q.lat;

    // R3: either latch address loads the latch on the next edge
    p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lat || wr_port) |=> (lat_bits == $past(wdata)));
    // R8: direction write lands on the next edge
    p_dir_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_bits == $past(wdata)));
    // R10: direction holds without its strobe (R7: no override path into it)
    p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_bits));
    // R10: latch holds without a strobe
    p_lat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lat || wr_port) |=> $stable(lat_bits));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_bits,
    input  logic [WIDTH-1:0] lat_bits,
    input  logic [WIDTH-1:0] periph_sel,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_comb begin
                if (periph_sel[b]) begin
                    pad_out[b] = periph_dout[b];
                    pad_oe[b]  = periph_oe[b];
                end else begin
                    pad_out[b] = lat_bits[b];
                    pad_oe[b]  = ~dir_bits[b];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lat,
    input  logic             wr_port,
    input  logic             wr_dir,
    input  logic             rd_lat,
    input  logic             rd_port,
    input  logic             rd_dir,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] periph_sel,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] periph_din
);
    logic [WIDTH-1:0] dir_bits, lat_bits, pin_sync;
    rd_src_e          rd_src;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lat   (wr_lat),
        .wr_port  (wr_port),
        .wr_dir   (wr_dir),
        .wdata    (wdata),
        .dir_bits (dir_bits),
        .lat_bits (lat_bits)
    );

    gpio_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .dir_bits    (dir_bits),
        .lat_bits    (lat_bits),
        .periph_sel  (periph_sel),
        .periph_dout (periph_dout),
        .periph_oe   (periph_oe),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );

    assign periph_din = pin_sync;
    assign rd_src     = pick_read(rd_dir, rd_lat, rd_port);

    always_comb begin
        unique case (rd_src)
            RSEL_DIR:  rdata = dir_bits;
            RSEL_LAT:  rdata = lat_bits;
            RSEL_PORT: rdata = pin_sync;
            default:   rdata = '0;
        endcase
    end

    // R6: a taken-over bit carries the peripheral data on the pad
    p_periph_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_sel & (pad_out ^ periph_dout)) == '0));
    // R7: a taken-over bit carries the peripheral enable on the pad
    p_periph_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_sel & (pad_oe ^ periph_oe)) == '0));
    // R9: an idle read bus is zero
    p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_dir || rd_lat || rd_port) |-> (rdata == '0));
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
    localparam int W = 8;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_lat = 0, wr_port = 0, wr_dir = 0, rd_lat = 0, rd_port = 0, rd_dir = 0;
    logic [W-1:0] wdata = '0, periph_sel = '0, periph_dout = '0, periph_oe = '0, pad_in = '0;
    logic [W-1:0] rdata, pad_out, pad_oe, periph_din;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_port #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_gpio_port (
        .clk(clk), .rst_n(rst_n),
        .wr_lat(wr_lat), .wr_port(wr_port), .wr_dir(wr_dir),
        .rd_lat(rd_lat), .rd_port(rd_port), .rd_dir(rd_dir),
        .wdata(wdata), .rdata(rdata),
        .periph_sel(periph_sel), .periph_dout(periph_dout), .periph_oe(periph_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .periph_din(periph_din)
    );

    // Behavioural reference
    int unsigned m_dir = 'hFF;
    int unsigned m_lat = 0;
    int unsigned m_pins[$];
    initial for (int i = 0; i < SYNC; i++) m_pins.push_back(0);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 'hFF;
            m_lat = 0;
            m_pins.delete();
            for (int i = 0; i < SYNC; i++) m_pins.push_back(0);
        end else begin
            if (wr_lat || wr_port) m_lat = wdata;
            if (wr_dir) m_dir = wdata;
            m_pins.push_back(pad_in);
            void'(m_pins.pop_front());
        end
    end

    task automatic chk(string tag, int unsigned act, int unsigned expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int unsigned eo, ed, er;
            eo = 0; ed = 0;
            for (int b = 0; b < W; b++) begin
                if (periph_sel[b]) begin
                    ed[b] = periph_dout[b];
                    eo[b] = periph_oe[b];
                end else begin
                    ed[b] = m_lat[b];
                    eo[b] = ~m_dir[b];
                end
            end
            if (rd_dir) er = m_dir;
            else if (rd_lat) er = m_lat;
            else if (rd_port) er = m_pins[0];
            else er = 0;
            chk("R2/R6 pad_out", pad_out, ed);
            chk("R2/R7 pad_oe", pad_oe, eo);
            chk("R5 periph_din", periph_din, m_pins[0]);
            chk("R4/R8/R9 rdata", rdata, er);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        {wr_lat, wr_port, wr_dir, rd_lat, rd_port, rd_dir} = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state seen through the normal interface
        rd_dir = 1; #1; chk("R1 dir after reset", rdata, 'hFF);
        rd_dir = 0; rd_lat = 1; #1; chk("R1 latch after reset", rdata, 0);
        rd_lat = 0; #1; chk("R1 pad_oe after reset", pad_oe, 0);
        rst_n = 1;
        tick();

        // R8: documented direction pattern
        wr_dir = 1; wdata = 'hCF; tick(); idle();
        #1; chk("R8 pad_oe for 0xCF", pad_oe, 'h30);
        rd_dir = 1; #1; chk("R8 dir readback", rdata, 'hCF); idle();

        // R3: port address loads the latch
        wr_port = 1; wdata = 'hA5; tick(); idle();
        rd_lat = 1; #1; chk("R3 latch via port write", rdata, 'hA5); idle();
        wr_lat = 1; wdata = 'h3C; tick(); idle();
        #1; chk("R3 pad_out from latch", pad_out, 'h3C);

        // R4: latch read ignores pads
        pad_in = 'hFF; tick(); tick();
        rd_lat = 1; #1; chk("R4 latch not pins", rdata, 'h3C); idle();
        // R5: pins visible through port read
        rd_port = 1; #1; chk("R5 port read", rdata, 'hFF); idle();

        // R7: override does not reach the direction register
        periph_sel = 'h0F; periph_oe = 'h0A; periph_dout = 'h05; tick();
        #1; chk("R7 pad_oe override", pad_oe, 'h3A);
        chk("R6 pad_out override", pad_out, 'h35);
        rd_dir = 1; #1; chk("R7 dir untouched", rdata, 'hCF); idle();
        periph_sel = '0;

        // R9: priority
        rd_dir = 1; rd_lat = 1; rd_port = 1; #1; chk("R9 dir wins", rdata, 'hCF);
        rd_dir = 0; #1; chk("R9 latch over port", rdata, 'h3C); idle();
        #1; chk("R9 idle read", rdata, 0);

        // R10 and mixed traffic
        for (int i = 0; i < 3000; i++) begin
            tick();
            wr_lat = ($urandom % 6) == 0;
            wr_port = ($urandom % 6) == 0;
            wr_dir = ($urandom % 7) == 0;
            rd_lat = ($urandom % 3) == 0;
            rd_port = ($urandom % 3) == 0;
            rd_dir = ($urandom % 4) == 0;
            wdata = W'($urandom);
            pad_in = W'($urandom);
            periph_sel = (i % 500 < 250) ? W'($urandom) : '0;
            periph_dout = W'($urandom);
            periph_oe = W'($urandom);
        end
        idle(); tick(); tick();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule